// File: doc/BRIEF.md
# Output Instruction Display Latch

This block sits beside a small processor's bus and decides when an output instruction is writing to the display port. It works from three signals: the late-cycle timing pulse, the memory read strobe (which is high while memory drives the data bus during an output instruction), and the three I/O select lines. When all three agree, the data bus byte is captured. When the timing pulse ends, that byte goes into a display register. The register drives two hexadecimal digits, and each nibble is also decoded into a seven-segment pattern.

A second latch shows the address bus. Its enable is always active, so it follows the bus one clock behind. Its value is also decoded into one seven-segment digit per nibble. Everything is sampled on a free-running system clock.

Top module: `out_port_display`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `disp_byte` reads 8'h00 and `addr_shown` reads all zeros.
- R2: A display capture is qualified while `tpb`, `mem_rd` and (`n_sel == 3'd4`) are all high. On the first clock edge that samples the qualified condition low after it was high, `disp_byte` loads the `data_in` value sampled at the last edge where the condition was high.
- R3: Between qualified cycles, `disp_byte` holds its value regardless of `data_in` activity.
- R4: A cycle with `tpb` and `mem_rd` high but `n_sel` at any value other than 4 leaves `disp_byte` unchanged.
- R5: `tpb` without `mem_rd`, or `mem_rd` without `tpb`, leaves `disp_byte` unchanged even when `n_sel` is 4.
- R6: `seg_hi` and `seg_lo` encode `disp_byte[7:4]` and `disp_byte[3:0]`. Bits are {g,f,e,d,c,b,a} and active high. The codes for 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R7: `addr_shown` equals `addr_in` as sampled at the previous clock edge.
- R8: `addr_seg` holds one 7-bit digit per address nibble. It uses the R6 table, and nibble k sits at bits [7k+6:7k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 8 | Processor data bus |
| tpb | input | 1 | Late-cycle timing pulse |
| mem_rd | input | 1 | Memory read strobe, active high |
| n_sel | input | 3 | I/O select lines |
| addr_in | input | ADDR_W | Processor address bus |
| disp_byte | output | 8 | Latched output byte |
| seg_hi | output | 7 | Segments for the upper nibble |
| seg_lo | output | 7 | Segments for the lower nibble |
| addr_shown | output | ADDR_W | Address register, always enabled |
| addr_seg | output | 7*ADDR_W/4 | Segments for each address nibble |

## Verification
A display byte is due one clock edge after the qualifying pulse ends. That is the first edge that samples the pulse low. An address value is due one edge after it is driven. The segment outputs follow their registers with no further delay.

The driver task sets inputs on falling edges. It pushes an expected item only after the rising edge at which the result becomes due. The monitor compares each item a short delay after the next falling edge, where every output has settled.

// File: rtl/out_port_display.sv
module out_port_display #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [2:0] DISP_N = 3'd4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       data_in,
  input  logic                    tpb,
  input  logic                    mem_rd,
  input  logic [2:0]              n_sel,
  input  logic [ADDR_W-1:0]       addr_in,
  output logic [DATA_W-1:0]       disp_byte,
  output logic [6:0]              seg_hi,
  output logic [6:0]              seg_lo,
  output logic [ADDR_W-1:0]       addr_shown,
  output logic [7*(ADDR_W/4)-1:0] addr_seg
);
  localparam int NDIG = ADDR_W / 4;

  function automatic logic [6:0] hex7(input logic [3:0] v);
    case (v)
      4'h0: hex7 = 7'h3F;  4'h1: hex7 = 7'h06;  4'h2: hex7 = 7'h5B;  4'h3: hex7 = 7'h4F;
      4'h4: hex7 = 7'h66;  4'h5: hex7 = 7'h6D;  4'h6: hex7 = 7'h7D;  4'h7: hex7 = 7'h07;
      4'h8: hex7 = 7'h7F;  4'h9: hex7 = 7'h6F;  4'hA: hex7 = 7'h77;  4'hB: hex7 = 7'h7C;
      4'hC: hex7 = 7'h39;  4'hD: hex7 = 7'h5E;  4'hE: hex7 = 7'h79;  default: hex7 = 7'h71;
    endcase
  endfunction

  logic              qual, qual_q;
  logic [DATA_W-1:0] shadow;

  assign qual = tpb & mem_rd & (n_sel == DISP_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q     <= 1'b0;
      shadow     <= '0;
      disp_byte  <= '0;
      addr_shown <= '0;
    end else begin
      qual_q     <= qual;
      addr_shown <= addr_in;
      if (qual) shadow <= data_in;
      if (qual_q && !qual) disp_byte <= shadow;
    end
  end

  assign seg_hi = hex7(disp_byte[7:4]);
  assign seg_lo = hex7(disp_byte[3:0]);

  for (genvar k = 0; k < NDIG; k++) begin : g_adig
    assign addr_seg[7*k +: 7] = hex7(addr_shown[4*k +: 4]);
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tpb && mem_rd && n_sel == DISP_N) |=> disp_byte == $past(data_in, 2));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(tpb && mem_rd && n_sel == DISP_N) |=> $stable(disp_byte));

  assert_seg_lit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_hi != 7'h00 && seg_lo != 7'h00);

  assert_addr_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> addr_shown == $past(addr_in));
endmodule

// File: tb/out_port_display_test.sv
module out_port_display_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  data_in = 0;
  logic        tpb = 0, mem_rd = 0;
  logic [2:0]  n_sel = 0;
  logic [15:0] addr_in = 0;
  logic [7:0]  disp_byte;
  logic [6:0]  seg_hi, seg_lo;
  logic [15:0] addr_shown;
  logic [27:0] addr_seg;

  out_port_display uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .tpb(tpb), .mem_rd(mem_rd),
    .n_sel(n_sel), .addr_in(addr_in), .disp_byte(disp_byte), .seg_hi(seg_hi),
    .seg_lo(seg_lo), .addr_shown(addr_shown), .addr_seg(addr_seg)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [7:0]  d;
    logic [15:0] a;
    string       req;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0]  exp_d = 8'h00;
  logic [15:0] exp_a = 16'h0000;

  function automatic logic [6:0] seg_ref(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                          7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  function automatic logic [27:0] aseg_ref(input logic [15:0] a);
    logic [27:0] r;
    for (int k = 0; k < 4; k++) r[7*k +: 7] = seg_ref(a[4*k +: 4]);
    return r;
  endfunction

  task automatic push(input string req);
    item_t it;
    it.d = exp_d; it.a = exp_a; it.req = req;
    q.push_back(it);
  endtask

  task automatic pulse(input logic [2:0] n, input logic t, input logic m,
                       input logic [7:0] first, input logic [7:0] last,
                       input int len, input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      tpb = t; mem_rd = m; n_sel = n;
      data_in = (i == len - 1) ? last : first;
    end
    @(negedge clk);
    tpb = 0; mem_rd = 0; data_in = ~last;
    @(posedge clk);
    if (t && m && n == 3'd4) exp_d = last;
    push(req);
  endtask

  task automatic set_addr(input logic [15:0] a, input string req);
    @(negedge clk);
    addr_in = a;
    @(posedge clk);
    exp_a = a;
    push(req);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (disp_byte !== it.d || seg_hi !== seg_ref(it.d[7:4]) ||
            seg_lo !== seg_ref(it.d[3:0]) || addr_shown !== it.a ||
            addr_seg !== aseg_ref(it.a)) begin
          bad++;
          $display("FAIL %s: disp=%h seg=%h/%h addr=%h aseg=%h expected disp=%h seg=%h/%h addr=%h aseg=%h",
                   it.req, disp_byte, seg_hi, seg_lo, addr_shown, addr_seg,
                   it.d, seg_ref(it.d[7:4]), seg_ref(it.d[3:0]), it.a, aseg_ref(it.a));
        end
      end
    end
  end

  initial begin
    #80000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    addr_in = 16'h5A5A;
    repeat (3) @(negedge clk);
    push("R1");
    rst_n = 1;
    @(posedge clk);
    exp_a = 16'h5A5A;

    pulse(3'd4, 1, 1, 8'h3C, 8'h3C, 1, "R2");
    pulse(3'd4, 1, 1, 8'hA5, 8'hE7, 3, "R2");

    for (int n = 0; n < 8; n++)
      if (n != 4) pulse(n[2:0], 1, 1, 8'h11, 8'hFF, 2, "R4");

    pulse(3'd4, 1, 0, 8'h22, 8'h99, 2, "R5");
    pulse(3'd4, 0, 1, 8'h33, 8'h88, 2, "R5");

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      data_in = 8'h40 + i[7:0];
      tpb = i[0];
    end
    @(negedge clk);
    tpb = 0;
    @(posedge clk);
    push("R3");

    for (int v = 0; v < 16; v++)
      pulse(3'd4, 1, 1, 8'h00, {v[3:0], 4'hF - v[3:0]}, 2, "R6");

    set_addr(16'h1234, "R7");
    set_addr(16'hABCD, "R8");
    set_addr(16'hFFFF, "R8");
    set_addr(16'h0000, "R7");

    repeat (2) @(negedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule